// File: doc/BRIEF.md
# Memory-Mapped 64-bit Interval Timer

This block is a register-programmed event timer built around a 64-bit up-counter. Software loads a 64-bit compare value as two bus-width halves, chooses a count clock and a divide ratio, and launches the counter. Each time the counter steps while equal to the compare value, it returns to zero and raises a period flag. The flag can drive a level interrupt. In continuous operation the counter keeps cycling. In single-shot operation it halts after the first match.

The count clock is either every bus clock cycle or a slower rate-enable input that is synchronous to the bus clock. The rate enable must toggle at no more than a third of the bus clock rate. A 4-bit prescaler divides the selected clock. Software reads the running count through two registers. Reading the low half latches the high half, so the pair forms one coherent 64-bit sample. Status clears when it is read. A software reset bit stops and clears the timer. An optional mode lets a write to the low compare half also start the timer.

Top module: `ivtimer64`

## Requirements
- R1: After reset every readable register returns zero, the counter is stopped and `irq` is low.
- R2: Read data appears on `bus_rdata` the cycle after `bus_re`. The mode (0x04), compare-low (0x08), compare-high (0x0C) and interrupt-enable (0x10) registers read back their written values. Mode reads back only its implemented bits, mask 0xF19. The control register (0x00) and unmapped offsets read zero, and writes to unmapped offsets change nothing.
- R3: Writing control (0x00) with bit 0 set clears the counter and starts counting. While the counter equals the compare value, a count step returns it to zero and sets the period flag, so one period takes compare+1 steps.
- R4: With mode bit 0 clear (single-shot), the counter stops at zero after the first match and stays there until started again.
- R5: With mode bit 0 set (continuous), the counter keeps running after each match.
- R6: Mode bits 11:8 hold a value p, and one count step happens every p+1 ticks of the selected clock.
- R7: With mode bit 3 set, the ticks are the rising edges of `gclk_en` rather than every bus clock cycle.
- R8: Reading counter-low (0x20) returns the low half and latches the high half. Reading counter-high (0x24) returns that latched value, not the live one.
- R9: Status (0x1C) bit 0 is the period flag and is cleared by a read of status. A match in the same cycle as that read keeps the flag set.
- R10: `irq` is high exactly when the period flag is set and interrupt-enable bit 0 is set.
- R11: Writing control with bit 8 set stops the counter, zeroes it and clears the flag. It wins over bit 0 written in the same word.
- R12: With mode bit 4 set, a write to compare-low also restarts the counter from zero. With bit 4 clear, such a write does not start it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gclk_en | input | 1 | Slow count-clock rate enable, synchronous to clk |
| bus_addr | input | ADDR_W (6) | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after bus_re |
| irq | output | 1 | Level interrupt |

## Verification
The bench times the match cycle exactly with and without the prescaler. A counter that ran one step long, or ignored the divide ratio, would raise `irq` a cycle early or late. In continuous mode it reads status in the very cycle of a match. A design that let the read clear win would lose that event and return zero on the next status read. It samples the counter low half just below the half-word boundary, then reads the high half after the boundary has passed. A design returning the live high half instead of the latched one would show the carry. It also checks that the slow clock enable, and not the bus clock, drives counting, that software reset beats start, and that a compare-low write starts the timer only in the mode that allows it.

// File: rtl/ivtimer64.sv
module ivtimer64 #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gclk_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int CNT_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_PLO  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_PHI  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(8'h24);
  localparam logic [DATA_W-1:0] MODE_MASK = DATA_W'(32'h0000_0F19);

  logic [DATA_W-1:0] mode_q, per_lo_q, per_hi_q, shadow_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [3:0]        psc_q;
  logic              ien_q, flag_q, run_q, g_q1, g_q2;

  wire              wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  wire              do_rst   = wr_ctrl && bus_wdata[8];
  wire              lo_start = bus_we && (bus_addr == A_PLO) && mode_q[4];
  wire              do_start = (wr_ctrl && bus_wdata[0]) || lo_start;
  wire              g_tick   = g_q1 & ~g_q2;
  wire              src_tick = mode_q[3] ? g_tick : 1'b1;
  wire [3:0]        pres     = mode_q[11:8];
  wire              step     = run_q && src_tick && (psc_q == pres);
  wire [CNT_W-1:0]  period   = {per_hi_q, per_lo_q};
  wire              hit      = step && (cnt_q == period);
  wire              rd_stat  = bus_re && (bus_addr == A_STAT);
  wire              rd_clo   = bus_re && (bus_addr == A_CLO);

  assign irq = flag_q & ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_q1 <= 1'b0;
      g_q2 <= 1'b0;
    end else begin
      g_q1 <= gclk_en;
      g_q2 <= g_q1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      per_lo_q <= '0;
      per_hi_q <= '0;
      ien_q    <= 1'b0;
    end else if (bus_we) begin
      case (bus_addr)
        A_MODE:  mode_q   <= bus_wdata & MODE_MASK;
        A_PLO:   per_lo_q <= bus_wdata;
        A_PHI:   per_hi_q <= bus_wdata;
        A_IEN:   ien_q    <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      psc_q <= '0;
    end else if (do_rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      psc_q <= '0;
    end else if (do_start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      psc_q <= '0;
    end else if (run_q && src_tick) begin
      if (psc_q == pres) begin
        psc_q <= '0;
        if (cnt_q == period) begin
          cnt_q <= '0;
          if (!mode_q[0]) run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end else begin
        psc_q <= psc_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (do_rst)  flag_q <= 1'b0;
    else if (hit)     flag_q <= 1'b1;
    else if (rd_stat) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q  <= '0;
      bus_rdata <= '0;
    end else begin
      if (rd_clo) shadow_q <= cnt_q[CNT_W-1:DATA_W];
      if (bus_re) begin
        case (bus_addr)
          A_MODE:  bus_rdata <= mode_q;
          A_PLO:   bus_rdata <= per_lo_q;
          A_PHI:   bus_rdata <= per_hi_q;
          A_IEN:   bus_rdata <= {{(DATA_W-1){1'b0}}, ien_q};
          A_STAT:  bus_rdata <= {{(DATA_W-1){1'b0}}, flag_q};
          A_CLO:   bus_rdata <= cnt_q[DATA_W-1:0];
          A_CHI:   bus_rdata <= shadow_q;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt_q == '0));
  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !mode_q[0] && !do_start && !do_rst) |=> !run_q);
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !do_start && !do_rst) |=> $stable(cnt_q));
  p_cont_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q[0] && !do_rst) |=> run_q);
  p_gpulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    g_tick |=> !g_tick);
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clo |=> $stable(shadow_q));
  p_match_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !do_rst) |=> flag_q);
  p_swrst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    do_rst |=> (!run_q && cnt_q == '0 && !flag_q && !irq));

endmodule

// File: tb/ivtimer64_test.sv
module ivtimer64_test;
  localparam int DW = 16;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          gclk_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_re = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int gcnt = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  ivtimer64 #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .gclk_en(gclk_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    gcnt = (gcnt + 1) % 4;
    gclk_en = (gcnt == 0);
  end

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (bus_re && exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", irq, 0);
    rd(6'h04, 0, "R1 mode");
    rd(6'h08, 0, "R1 plo");
    rd(6'h1C, 0, "R1 status");
    rd(6'h20, 0, "R1 cnt lo");

    // R2 readback and unmapped
    wr(6'h04, 16'hFFFF);
    rd(6'h04, 16'h0F19, "R2 mode mask");
    wr(6'h04, 16'h0000);
    wr(6'h08, 16'h1234);
    rd(6'h08, 16'h1234, "R2 plo");
    wr(6'h0C, 16'hABCD);
    rd(6'h0C, 16'hABCD, "R2 phi");
    wr(6'h14, 16'hFFFF);
    rd(6'h14, 0, "R2 unmapped");
    rd(6'h00, 0, "R2 ctrl");
    rd(6'h0C, 16'hABCD, "R2 phi after unmapped write");
    wr(6'h00, 16'h0100);

    // R3/R10 one-shot match timing, period 4
    wr(6'h0C, 0);
    wr(6'h08, 4);
    wr(6'h10, 1);
    rd(6'h10, 1, "R2 ien");
    wr(6'h00, 1);
    repeat (4) @(negedge clk);
    check("R3 no match before compare+1 steps", irq, 0);
    @(negedge clk);
    check("R3 match after compare+1 steps", irq, 1);
    wr(6'h10, 0);
    check("R10 irq masked", irq, 0);
    wr(6'h10, 1);
    check("R10 irq enabled", irq, 1);
    repeat (10) @(negedge clk);
    rd(6'h20, 0, "R4 one-shot stopped at zero");
    rd(6'h1C, 1, "R9 status set");
    rd(6'h1C, 0, "R9 status cleared by read");
    check("R10 irq after clear", irq, 0);
    repeat (20) @(negedge clk);
    rd(6'h1C, 0, "R4 no further match");
    rd(6'h20, 0, "R4 counter held");

    // R6 prescaler p=3, compare 1: match after 8 cycles
    wr(6'h00, 16'h0100);
    wr(6'h04, 16'h0300);
    wr(6'h08, 1);
    wr(6'h00, 1);
    repeat (7) @(negedge clk);
    check("R6 no match before 8 cycles", irq, 0);
    @(negedge clk);
    check("R6 match at 8 cycles", irq, 1);

    // R5/R9 continuous compare 3, matches every 4 cycles; read lands on a match
    wr(6'h00, 16'h0100);
    wr(6'h04, 16'h0001);
    wr(6'h08, 3);
    wr(6'h00, 1);
    repeat (10) @(negedge clk);
    rd(6'h1C, 1, "R5 continuous flag");
    rd(6'h1C, 1, "R9 match wins over read clear");
    rd(6'h1C, 0, "R9 cleared without match");
    repeat (3) @(negedge clk);
    check("R5 still matching", irq, 1);

    // R11 software reset
    wr(6'h00, 16'h0100);
    check("R11 irq cleared", irq, 0);
    repeat (5) @(negedge clk);
    rd(6'h20, 0, "R11 counter zero");
    rd(6'h1C, 0, "R11 flag cleared");
    wr(6'h00, 16'h0101);
    repeat (5) @(negedge clk);
    rd(6'h20, 0, "R11 reset beats start");

    // R7 generic clock: one-shot, p=1, compare 2
    wr(6'h04, 16'h0108);
    wr(6'h08, 2);
    wr(6'h00, 1);
    repeat (8) @(negedge clk);
    rd(6'h1C, 0, "R7 slow clock not yet matched");
    repeat (60) @(negedge clk);
    rd(6'h1C, 1, "R7 slow clock matched");

    // R12 start on low compare write
    wr(6'h00, 16'h0100);
    wr(6'h04, 16'h0000);
    wr(6'h08, 5);
    repeat (10) @(negedge clk);
    rd(6'h20, 0, "R12 no start without mode bit");
    rd(6'h1C, 0, "R12 no match without mode bit");
    wr(6'h04, 16'h0010);
    wr(6'h08, 5);
    repeat (10) @(negedge clk);
    rd(6'h1C, 1, "R12 low write started timer");

    // R8 coherent read across the half-word boundary
    wr(6'h00, 16'h0100);
    wr(6'h04, 16'h0001);
    wr(6'h0C, 2);
    wr(6'h08, 0);
    wr(6'h00, 1);
    repeat (65531) @(negedge clk);
    rd(6'h20, 16'hFFFC, "R8 low before carry");
    repeat (20) @(negedge clk);
    rd(6'h24, 16'h0000, "R8 high is latched copy");
    rd(6'h20, 16'h0014, "R8 low after carry");
    rd(6'h24, 16'h0001, "R8 high after carry");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule